// File: doc/BRIEF.md
# Flash Command Sequencer with Access-Error Guard

This block sits between a processor bus and a banked flash array. It accepts word-program, sector-erase and whole-block-erase requests, and it only starts one after a strict three-step launch. First the processor writes one aligned data word into the flash address space. Next it writes a command code into the command register. Last it sets the launch bit in the status register. If any other register write, array write or read of the targeted block arrives between those steps, the sequence is dropped and a sticky access-error flag is raised.

The processor sees a 16-bit address space. The window at 0x8000–0xBFFF is steered by a 4-bit page register. The windows at 0x4000–0x7FFF and 0xC000–0xFFFF always map to the two top pages, 0xE and 0xF. A page selects a 64-K block whose number is the inverse of page bits [3:2]. A separate block-select register must agree with that block before a sequence can start.

The array itself is a behavioural model with a configurable busy time. It keeps a folded image of each block: the low two sector bits and the low three word bits of every word address. While an operation runs, both status flags stay low.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset, `buf_empty` and `op_done` are 1 and `acc_err` is 0, the page and block-select registers are 0, and every array word reads 0xFFFF.
- R2: An accepted array write, then a command write (register 2), then a status write with bit 7 set (register 3) launches the operation. `buf_empty` and `op_done` both read 0 from the cycle after the launch write.
- R3: Once launched, `buf_empty` and `op_done` stay low for exactly max(BUSY_CYC, 2^(KEEP_SEC+KEEP_OFF)) cycles (40 by default), then both return to 1 together.
- R4: Command 0x20 programs one word: the new stored value is the old value ANDed with the data word from step one.
- R5: Command 0x40 erases a sector to 0xFFFF. The sector is every word whose 15-bit word address has the same bits [14:8] as the captured one. The low 8 address bits and the data word are ignored.
- R6: Command 0x41 erases the whole 64-K block that holds the step-one address. Which address in the block was used, and the data word, make no difference.
- R7: Any command code other than 0x20, 0x40 or 0x41 written at step two sets `acc_err`, drops the sequence and leaves the array unchanged.
- R8: Between steps, a write to any register other than the expected step, or a second array write inside flash space, sets `acc_err` and drops the sequence. No launch follows.
- R9: Between steps, a read of the targeted block sets `acc_err` and drops the sequence. A read of a different block has no effect on the sequence.
- R10: An address maps to a page: the page register for 0x8000–0xBFFF, page 0xE for 0x4000–0x7FFF, page 0xF for 0xC000–0xFFFF. Its block is the inverse of page bits [3:2] and its word address is {page[1:0], addr[13:1]}. A step-one write whose block differs from the block-select register sets `acc_err` and starts nothing.
- R11: A status write with bit 4 set and bit 7 clear clears `acc_err` when no sequence is pending. While `acc_err` is set, step-one writes are ignored.
- R12: With no sequence pending, a command-register write or a status write with bit 7 set raises `acc_err`.
- R13: While an operation runs, array reads return 0xFFFF and array writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Array write strobe (step one) |
| bus_rd | input | 1 | Array read strobe |
| bus_addr | input | 16 | Processor byte address |
| bus_wdata | input | 16 | Array write data |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register: 0 page, 1 block select, 2 command, 3 status |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 16 | Array read data, valid the cycle after `bus_rd` |
| buf_empty | output | 1 | Command buffer empty flag |
| op_done | output | 1 | Operation complete flag |
| acc_err | output | 1 | Sticky access-error flag |

## Verification
The bench attacks the sequence guard from every side. It sends register writes of each kind at steps two and three, a stray second word write, an invalid code, and a read of the target block. A guard with a hole would launch anyway, and the per-cycle model would see the flags drop. A guard that is too strict would abort when a read hits a different block through a fixed window. The bench also checks erase-address masking with junk in the low sector bits, and a mass erase issued from a fixed window with an unrelated page value. It checks that step-one writes are ignored while the error flag is set, proved by the flag clearing on the next status write. A wrong mask or a wrong block mapping leaves stale words or wipes neighbours, and the read-back compare catches it.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [1:0] SEL_PAGE = 2'd0;
  localparam logic [1:0] SEL_BSEL = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int STAT_GO  = 7;
  localparam int STAT_CLR = 4;

  localparam logic [7:0] CODE_PROG = 8'h20;
  localparam logic [7:0] CODE_SERA = 8'h40;
  localparam logic [7:0] CODE_MERA = 8'h41;

  typedef enum logic [1:0] {OP_PROG, OP_SERA, OP_MERA} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WCMD, ST_WGO, ST_RUN} seq_st_e;
endpackage

// File: rtl/fcs_addr_map.sv
module fcs_addr_map #(
  parameter int BLK_W = 2,
  localparam int PG_W = BLK_W + 2,
  localparam int WA_W = 15
) (
  input  logic [15:0]      addr,
  input  logic [PG_W-1:0]  page,
  output logic             in_flash,
  output logic [BLK_W-1:0] blk,
  output logic [WA_W-1:0]  waddr
);
  logic [PG_W-1:0] eff;
  logic unused_lsb;
  assign unused_lsb = addr[0];

  always_comb begin
    case (addr[15:14])
      2'b01:   eff = {{(PG_W-1){1'b1}}, 1'b0};
      2'b11:   eff = {PG_W{1'b1}};
      default: eff = page;
    endcase
    in_flash = (addr[15:14] != 2'b00);
    blk      = ~eff[PG_W-1 -: BLK_W];
    waddr    = {eff[1:0], addr[13:1]};
  end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int BLK_W = 2,
  parameter int DW    = 16,
  localparam int PG_W = BLK_W + 2,
  localparam int WA_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             in_flash,
  input  logic [BLK_W-1:0] blk,
  input  logic [WA_W-1:0]  waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic             done,
  output logic [PG_W-1:0]  page_q,
  output logic             go,
  output op_e              op_q,
  output logic [BLK_W-1:0] c_blk,
  output logic [WA_W-1:0]  c_wa,
  output logic [DW-1:0]    c_dat,
  output logic             cbe_q,
  output logic             ccf_q,
  output logic             acc_q
);
  seq_st_e          st;
  logic [BLK_W-1:0] bsel_q;
  op_e  op_dec;
  logic code_ok, tgt_rd, arr_touch, cmd_ok, go_ok, step_ok, abort;

  always_comb begin
    code_ok = 1'b1;
    op_dec  = OP_PROG;
    case (reg_wdata)
      CODE_PROG: op_dec = OP_PROG;
      CODE_SERA: op_dec = OP_SERA;
      CODE_MERA: op_dec = OP_MERA;
      default:   code_ok = 1'b0;
    endcase
    tgt_rd    = bus_rd && in_flash && (blk == c_blk);
    arr_touch = (bus_wr && in_flash) || tgt_rd;
    cmd_ok    = reg_wr && (reg_sel == SEL_CMD) && code_ok;
    go_ok     = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[STAT_GO];
    step_ok   = (st == ST_WCMD) ? cmd_ok : go_ok;
    abort     = ((st == ST_WCMD) || (st == ST_WGO)) && !step_ok && (reg_wr || arr_touch);
  end

  assign go = (st == ST_WGO) && go_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      page_q <= '0;
      bsel_q <= '0;
      acc_q  <= 1'b0;
      cbe_q  <= 1'b1;
      ccf_q  <= 1'b1;
      op_q   <= OP_PROG;
      c_blk  <= '0;
      c_wa   <= '0;
      c_dat  <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_RUN: begin
          if (reg_wr) begin
            case (reg_sel)
              SEL_PAGE: page_q <= reg_wdata[PG_W-1:0];
              SEL_BSEL: bsel_q <= reg_wdata[BLK_W-1:0];
              SEL_CMD:  acc_q  <= 1'b1;
              default: begin
                if (reg_wdata[STAT_GO])       acc_q <= 1'b1;
                else if (reg_wdata[STAT_CLR]) acc_q <= 1'b0;
              end
            endcase
          end else if ((st == ST_IDLE) && bus_wr && in_flash && !acc_q) begin
            if (blk != bsel_q) begin
              acc_q <= 1'b1;
            end else begin
              c_blk <= blk;
              c_wa  <= waddr;
              c_dat <= wdata;
              st    <= ST_WCMD;
            end
          end
          if ((st == ST_RUN) && done) begin
            st    <= ST_IDLE;
            cbe_q <= 1'b1;
            ccf_q <= 1'b1;
          end
        end
        default: begin
          if (abort) begin
            acc_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (step_ok) begin
            if (st == ST_WCMD) begin
              op_q <= op_dec;
              st   <= ST_WGO;
            end else begin
              st    <= ST_RUN;
              cbe_q <= 1'b0;
              ccf_q <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fcs_array.sv
module fcs_array
  import fcs_pkg::*;
#(
  parameter int BLK_W    = 2,
  parameter int DW       = 16,
  parameter int SEC_LSB  = 8,
  parameter int KEEP_SEC = 2,
  parameter int KEEP_OFF = 3,
  parameter int BUSY_CYC = 40,
  localparam int WA_W  = 15,
  localparam int ENT_W = KEEP_SEC + KEEP_OFF,
  localparam int ENT   = 1 << ENT_W,
  localparam int IDX_W = BLK_W + ENT_W,
  localparam int DEPTH = 1 << IDX_W,
  localparam int RUN   = (BUSY_CYC > ENT) ? BUSY_CYC : ENT,
  localparam int CW    = $clog2(RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  op_e              op,
  input  logic [BLK_W-1:0] blk,
  input  logic [WA_W-1:0]  waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [WA_W-1:0]  rd_waddr,
  output logic             done,
  output logic [DW-1:0]    rd_data
);
  localparam logic [CW-1:0] ENT_C  = CW'(ENT);
  localparam logic [CW-1:0] LAST_C = CW'(RUN - 1);

  logic [DW-1:0]       mem [DEPTH];
  logic [DW-1:0]       rdq, wdat, dat_q;
  logic                busy, rd_ones, we, in_walk;
  logic [CW-1:0]       el;
  op_e                 op_q;
  logic [BLK_W-1:0]    blk_q;
  logic [KEEP_SEC-1:0] sec_q;
  logic [KEEP_OFF-1:0] off_q;
  logic [ENT_W-1:0]    ent;
  logic [IDX_W-1:0]    widx, ridx, pidx;
  logic unused_wa;
  assign unused_wa = ^{waddr, rd_waddr};

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_comb begin
    ent     = el[ENT_W-1:0];
    in_walk = busy && (el < ENT_C);
    pidx    = {blk_q, sec_q, off_q};
    widx    = {blk_q, ent};
    wdat    = '1;
    we      = 1'b0;
    case (op_q)
      OP_PROG: begin
        widx = pidx;
        wdat = rdq & dat_q;
        we   = busy && (el == CW'(1));
      end
      OP_SERA: we = in_walk && (ent[ENT_W-1 -: KEEP_SEC] == sec_q);
      default: we = in_walk;
    endcase
    ridx = busy ? pidx : {rd_blk, rd_waddr[SEC_LSB +: KEEP_SEC], rd_waddr[0 +: KEEP_OFF]};
    done = busy && (el == LAST_C);
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
    rdq <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      el      <= '0;
      rd_ones <= 1'b0;
      op_q    <= OP_PROG;
      blk_q   <= '0;
      sec_q   <= '0;
      off_q   <= '0;
      dat_q   <= '0;
    end else begin
      rd_ones <= busy;
      if (go) begin
        busy  <= 1'b1;
        el    <= '0;
        op_q  <= op;
        blk_q <= blk;
        sec_q <= waddr[SEC_LSB +: KEEP_SEC];
        off_q <= waddr[0 +: KEEP_OFF];
        dat_q <= wdata;
      end else if (busy) begin
        el <= el + CW'(1);
        if (done) busy <= 1'b0;
      end
    end
  end

  assign rd_data = rd_ones ? {DW{1'b1}} : rdq;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int BLK_W    = 2,
  parameter int DATA_W   = 16,
  parameter int SEC_LSB  = 8,
  parameter int KEEP_SEC = 2,
  parameter int KEEP_OFF = 3,
  parameter int BUSY_CYC = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_empty,
  output logic              op_done,
  output logic              acc_err
);
  import fcs_pkg::*;
  localparam int PG_W = BLK_W + 2;
  localparam int WA_W = 15;

  logic [PG_W-1:0]  page_q;
  logic             in_flash, go, done;
  logic [BLK_W-1:0] blk, c_blk;
  logic [WA_W-1:0]  waddr, c_wa;
  logic [DATA_W-1:0] c_dat;
  op_e              op_q;

  fcs_addr_map #(.BLK_W(BLK_W)) u_map (
    .addr(bus_addr), .page(page_q), .in_flash(in_flash), .blk(blk), .waddr(waddr)
  );

  fcs_seq #(.BLK_W(BLK_W), .DW(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .in_flash(in_flash),
    .blk(blk), .waddr(waddr), .wdata(bus_wdata), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .done(done), .page_q(page_q), .go(go), .op_q(op_q),
    .c_blk(c_blk), .c_wa(c_wa), .c_dat(c_dat), .cbe_q(buf_empty), .ccf_q(op_done),
    .acc_q(acc_err)
  );

  fcs_array #(
    .BLK_W(BLK_W), .DW(DATA_W), .SEC_LSB(SEC_LSB), .KEEP_SEC(KEEP_SEC),
    .KEEP_OFF(KEEP_OFF), .BUSY_CYC(BUSY_CYC)
  ) u_arr (
    .clk(clk), .rst(rst), .go(go), .op(op_q), .blk(c_blk), .waddr(c_wa), .wdata(c_dat),
    .rd_blk(blk), .rd_waddr(waddr), .done(done), .rd_data(rd_data)
  );
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
  parameter int DATA_W   = 16,
  parameter int KEEP_SEC = 2,
  parameter int KEEP_OFF = 3,
  parameter int BUSY_CYC = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [7:0]        reg_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              buf_empty,
  input logic              op_done,
  input logic              acc_err
);
  localparam int ENT = 1 << (KEEP_SEC + KEEP_OFF);
  localparam int RUN = (BUSY_CYC > ENT) ? BUSY_CYC : ENT;
  int lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || op_done) lo_cnt <= 0;
    else                lo_cnt <= lo_cnt + 1;
  end

  p_flags_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (buf_empty == op_done));
  p_launch_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(op_done) |-> $past(reg_wr && reg_sel == 2'd3 && reg_wdata[7]));
  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(op_done) |-> (lo_cnt == RUN));
  p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !op_done |-> (lo_cnt < RUN));
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_err) |-> $past(reg_wr || bus_wr || bus_rd));
  p_err_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(acc_err) |-> $past(reg_wr && reg_sel == 2'd3 && reg_wdata[4] && !reg_wdata[7]));
  p_busy_read_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !op_done) |=> (rd_data == {DATA_W{1'b1}}));
endmodule

bind flash_cmd_seq fcs_chk #(
  .DATA_W(DATA_W), .KEEP_SEC(KEEP_SEC), .KEEP_OFF(KEEP_OFF), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_data(rd_data),
  .buf_empty(buf_empty), .op_done(op_done), .acc_err(acc_err)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int RUN = 40;
  localparam int SEC_LSB = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, reg_wr = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic [1:0]  reg_sel = 0;
  logic [7:0]  reg_wdata = 0;
  logic [15:0] rd_data;
  logic buf_empty, op_done, acc_err;

  int n_chk = 0, n_fail = 0, cyc = 0;

  flash_cmd_seq dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .buf_empty(buf_empty), .op_done(op_done), .acc_err(acc_err)
  );

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [15:0] mm [int];
  int  m_step, m_left, c_blk, c_wa, c_cmd;
  bit  m_acc, rd_pend;
  int  m_page, m_bsel;
  logic [15:0] c_dat, exp_rd;

  function automatic void dec(input logic [15:0] a, input int pg,
                              output bit inf, output int b, output int wa);
    int ep;
    ep  = (a[15:14] == 2'b01) ? 14 : (a[15:14] == 2'b11) ? 15 : pg;
    inf = (a[15:14] != 2'b00);
    b   = 3 - (ep / 4);
    wa  = (ep % 4) * 8192 + int'(a[13:1]);
  endfunction

  function automatic logic [15:0] mget(input int key);
    return mm.exists(key) ? mm[key] : 16'hFFFF;
  endfunction

  task automatic m_apply();
    int dq[$];
    if (c_cmd == 8'h20) begin
      mm[c_blk * 32768 + c_wa] = mget(c_blk * 32768 + c_wa) & c_dat;
    end else begin
      foreach (mm[k])
        if (k / 32768 == c_blk &&
            (c_cmd == 8'h41 || ((k % 32768) >> SEC_LSB) == (c_wa >> SEC_LSB)))
          dq.push_back(k);
      foreach (dq[i]) mm.delete(dq[i]);
    end
  endtask

  always @(posedge clk) begin
    bit inf; int b, wa; bit ok_cmd, bad;
    if (rst) begin
      m_step = 0; m_left = 0; m_acc = 0; m_page = 0; m_bsel = 0; rd_pend = 0;
      c_blk = 0; c_wa = 0; c_cmd = 0; c_dat = 0;
    end else begin
      dec(bus_addr, m_page, inf, b, wa);
      rd_pend = bus_rd;
      if (bus_rd) exp_rd = (m_step == 3) ? 16'hFFFF : mget(b * 32768 + wa);
      ok_cmd = (reg_wdata == 8'h20 || reg_wdata == 8'h40 || reg_wdata == 8'h41);
      bad = reg_wr || (bus_wr && inf) || (bus_rd && inf && b == c_blk);
      if (m_step == 0 || m_step == 3) begin
        if (reg_wr) begin
          if (reg_sel == 0) m_page = int'(reg_wdata[3:0]);
          else if (reg_sel == 1) m_bsel = int'(reg_wdata[1:0]);
          else if (reg_sel == 2) m_acc = 1;
          else if (reg_wdata[7]) m_acc = 1;
          else if (reg_wdata[4]) m_acc = 0;
        end else if (m_step == 0 && bus_wr && inf && !m_acc) begin
          if (b != m_bsel) m_acc = 1;
          else begin c_blk = b; c_wa = wa; c_dat = bus_wdata; m_step = 1; end
        end
        if (m_step == 3) begin
          m_left--;
          if (m_left == 0) m_step = 0;
        end
      end else if (m_step == 1) begin
        if (reg_wr && reg_sel == 2 && ok_cmd) begin c_cmd = int'(reg_wdata); m_step = 2; end
        else if (bad) begin m_acc = 1; m_step = 0; end
      end else begin
        if (reg_wr && reg_sel == 3 && reg_wdata[7]) begin m_apply(); m_step = 3; m_left = RUN; end
        else if (bad) begin m_acc = 1; m_step = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (buf_empty !== (m_step != 3) || op_done !== (m_step != 3)) begin
        n_fail++;
        $display("FAIL R3 flags cbe/ccf actual=%b/%b expected=%b", buf_empty, op_done, m_step != 3);
      end
      n_chk++;
      if (acc_err !== m_acc) begin
        n_fail++;
        $display("FAIL R8 acc_err actual=%b expected=%b", acc_err, m_acc);
      end
      if (rd_pend) begin
        n_chk++;
        if (rd_data !== exp_rd) begin
          n_fail++;
          $display("FAIL R4 rd_data model actual=%h expected=%h", rd_data, exp_rd);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic aw(input logic [15:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; @(negedge clk); bus_wr = 0;
  endtask

  task automatic ar(input logic [15:0] a, input logic [15:0] e, input string tag);
    bus_rd = 1; bus_addr = a; @(negedge clk); bus_rd = 0;
    chk(rd_data === e, tag, int'(rd_data), int'(e));
  endtask

  task automatic rw(input logic [1:0] s, input logic [7:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d; @(negedge clk); reg_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && !op_done; i++) @(negedge clk);
  endtask

  task automatic run(input logic [15:0] a, input logic [15:0] d, input logic [7:0] c);
    aw(a, d); rw(2, c); rw(3, 8'h80); wait_idle();
  endtask

  task automatic clr();
    rw(3, 8'h10);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL R3 watchdog actual=%0d expected<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(buf_empty && op_done && !acc_err, "R1 flags after reset", {acc_err, op_done, buf_empty}, 3);
    ar(16'h8204, 16'hFFFF, "R1 erased after reset");
    // R2/R3/R4: program, block 3 via page 0
    rw(1, 8'd3);
    aw(16'h8204, 16'h5A3C); rw(2, 8'h20); rw(3, 8'h80);
    chk(!buf_empty && !op_done, "R2 flags low after launch", {op_done, buf_empty}, 0);
    n = 0;
    while (!op_done && n < 500) begin n++; @(negedge clk); end
    chk(n == RUN, "R3 busy length", n, RUN);
    chk(buf_empty && op_done, "R3 flags back", {op_done, buf_empty}, 3);
    ar(16'h8204, 16'h5A3C, "R4 program");
    run(16'h8204, 16'h0FF0, 8'h20);
    ar(16'h8204, 16'h0A30, "R4 program AND");
    run(16'h8206, 16'h1234, 8'h20);
    run(16'h8404, 16'hBEEF, 8'h20);
    run(16'h8004, 16'h7777, 8'h20);
    // R5: sector erase, junk low bits and data
    run(16'h83A4, 16'h0000, 8'h40);
    ar(16'h8204, 16'hFFFF, "R5 sector erased");
    ar(16'h8206, 16'hFFFF, "R5 sector erased 2");
    ar(16'h8404, 16'hBEEF, "R5 other sector kept");
    ar(16'h8004, 16'h7777, "R5 other sector kept 2");
    // R6: mass erase block 2 via different page in block
    rw(0, 8'h4); rw(1, 8'd2);
    run(16'h8008, 16'h1111, 8'h20);
    ar(16'h8008, 16'h1111, "R6 setup program");
    rw(0, 8'h5);
    run(16'hBFFE, 16'h0000, 8'h41);
    rw(0, 8'h4);
    ar(16'h8008, 16'hFFFF, "R6 mass erased");
    rw(0, 8'h0);
    ar(16'h8404, 16'hBEEF, "R6 other block kept");
    // R10: fixed window ignores page, block 0
    rw(0, 8'hC); rw(1, 8'd0);
    run(16'h8002, 16'h2222, 8'h20);
    ar(16'h8002, 16'h2222, "R10 block0 program");
    rw(0, 8'h3);
    run(16'hC100, 16'h0000, 8'h41);
    rw(0, 8'hC);
    ar(16'h8002, 16'hFFFF, "R10 fixed window mass erase");
    // R10: block select mismatch
    rw(0, 8'h0); rw(1, 8'd1);
    aw(16'h8404, 16'h0000);
    chk(acc_err && buf_empty, "R10 bsel mismatch", acc_err, 1);
    clr();
    chk(!acc_err, "R11 clear", acc_err, 0);
    rw(1, 8'd3);
    // R7: invalid code
    aw(16'h8404, 16'h0000); rw(2, 8'h21);
    chk(acc_err, "R7 bad code", acc_err, 1);
    rw(3, 8'h80);
    chk(op_done, "R7 no launch", op_done, 1);
    clr();
    ar(16'h8404, 16'hBEEF, "R7 array unchanged");
    // R8: aborts by register write / second array write
    aw(16'h8404, 16'h0000); rw(0, 8'h0);
    chk(acc_err, "R8 page write aborts", acc_err, 1);
    clr();
    aw(16'h8404, 16'h0000); rw(2, 8'h20); rw(1, 8'd3);
    chk(acc_err, "R8 bsel write aborts", acc_err, 1);
    clr();
    aw(16'h8404, 16'h0000); rw(2, 8'h20); aw(16'h8404, 16'h0000);
    chk(acc_err, "R8 second word write aborts", acc_err, 1);
    rw(3, 8'h80);
    chk(op_done, "R8 no launch", op_done, 1);
    clr();
    ar(16'h8404, 16'hBEEF, "R8 array unchanged");
    // R9: reads of target vs other block
    aw(16'h8404, 16'h00FF);
    ar(16'h8000, 16'hFFFF, "R9 target read data");
    chk(acc_err, "R9 target read aborts", acc_err, 1);
    clr();
    aw(16'h8404, 16'h00FF);
    ar(16'h4000, 16'hFFFF, "R9 other block read data");
    chk(!acc_err, "R9 other block read harmless", acc_err, 0);
    rw(2, 8'h20); rw(3, 8'h80); wait_idle();
    ar(16'h8404, 16'h00EF, "R9 sequence completed");
    // R12 and R11: command outside sequence, ignored step one while error
    rw(2, 8'h20);
    chk(acc_err, "R12 command when idle", acc_err, 1);
    aw(16'h8404, 16'h0000);
    clr();
    chk(!acc_err, "R11 step one ignored while error", acc_err, 0);
    rw(3, 8'h80);
    chk(acc_err && op_done, "R12 launch when idle", acc_err, 1);
    clr();
    // R13: reads and writes while busy
    aw(16'h8004, 16'h0F0F); rw(2, 8'h20); rw(3, 8'h80);
    ar(16'h8004, 16'hFFFF, "R13 read while busy");
    aw(16'h8004, 16'h0000);
    wait_idle();
    ar(16'h8004, 16'h0707, "R13 busy write ignored");
    chk(!acc_err, "R13 no error", acc_err, 0);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule